// File: doc/BRIEF.md
# Virtual Node Discovery Sequencer

This block is a host-side controller that talks to a scan engine one command at a time. Each command is either an instruction-register scan or a data-register scan, given as a bit length and an output value. Data scans also hand back captured bits, of which this block consumes the lowest four. After a start pulse the controller runs a fixed script. It selects the hub's information instruction and reads the hub configuration word as eight nibble scans. It then reads one identity word per node in the same way and remembers the address of a node whose identity code equals a target value. Finally it loads a chosen virtual instruction into that node.

The lengths and payloads of the later scans are not fixed. They come from the words read back: the node count sets how many identity words follow and how wide the address field is, and the virtual instruction width m sets where the address lands in the final payload. When the run ends, the block presents done or error, the matching node address, m, the node count and the raw configuration word. These outputs hold until the next start.

Top module: `vnode_discover_seq`

## Requirements
- R1: After reset, cmd_valid, done and error are low, and node_addr, m_width, node_count and hub_cfg are zero.
- R2: After start, the first three commands are, in order: an IR scan of IR_LEN bits carrying SEL1_CODE (default 0x0E, IR_LEN 10); a DR scan of FLUSH_LEN bits (default 64) carrying zero; and an IR scan of IR_LEN bits carrying SEL0_CODE (default 0x0C).
- R3: The next eight commands are DR scans of length 4 carrying zero. Each returned nibble (rsp_data[3:0]) shifts the 32-bit word right by four and enters at bits [31:28]. The word built from these eight nibbles appears on hub_cfg.
- R4: node_count equals hub_cfg[26:19], and m_width equals hub_cfg[7:0].
- R5: For each node, eight more 4-bit zero DR scans build that node's identity word, whose ID field is bits [26:19]. Node index i (from 0) has address i+1. A node matches when its ID equals TARGET_ID (default 0x08). When several nodes match, node_addr takes the last match. Every node is always read.
- R6: When no node matches, including a node count of zero, error rises and no further command is issued. done and error are never high together.
- R7: After a match, the block issues an IR scan of SEL1_CODE, then a DR scan, then an IR scan of SEL0_CODE. done rises after the response to that last scan.
- R8: The final DR scan has length aw + m_width and carries (node_addr << m_width) | VIR_CMD (default 0x8). aw is the number of significant bits in node_count (count 3 gives 2, count 8 gives 4).
- R9: While cmd_valid is high and cmd_ready is low, cmd_is_dr, cmd_len and cmd_data hold steady. Once a command is accepted, no new request appears until rsp_done has been seen. rsp_done counts only in a cycle after the acceptance.
- R10: A start pulse during a run has no effect. A start pulse after done or error begins a fresh run and clears the previous results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a discovery run when idle, done or failed |
| cmd_valid | output | 1 | Scan command request |
| cmd_ready | input | 1 | Scan engine accepts the command |
| cmd_is_dr | output | 1 | 1 for a DR scan, 0 for an IR scan |
| cmd_len | output | LEN_W (9) | Scan length in bits |
| cmd_data | output | DATA_W (64) | Bits shifted out, LSB first |
| rsp_done | input | 1 | Scan finished; rsp_data valid |
| rsp_data | input | 4 | Lowest four captured bits of the finished scan |
| done | output | 1 | Run completed with the instruction loaded |
| error | output | 1 | Run ended with no matching node |
| node_addr | output | 9 | Address of the last matching node |
| m_width | output | 8 | Virtual instruction width m |
| node_count | output | 8 | Number of nodes on the hub |
| hub_cfg | output | 32 | Assembled hub configuration word |

## Verification
The bench runs cases with several matching nodes, a single node with m of 1, a zero node count, a list with no match, and a node count of 8 whose only match is the last node. A design that kept the first match, stopped reading early, or miscounted the address width would send a wrong final length or payload, and the bench compares every command against an expected script. A nibble assembled in the wrong direction shows up as a wrong hub_cfg, a wrong node count, and a different number of identity scans. Random ready and response delays expose request fields that change while a command is pending, and a second request that appears before the response. A start pulse in the middle of a run must leave the command stream unchanged.

// File: rtl/vnd_pkg.sv
package vnd_pkg;
  localparam int CFG_W  = 32;
  localparam int NIB_W  = 4;
  localparam int ID_LSB = 19;
  localparam int ID_W   = 8;
  localparam int M_LSB  = 0;
  localparam int M_W    = 8;
  localparam int ADDR_W = ID_W + 1;
  localparam int NIBS_PER_WORD = CFG_W / NIB_W;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SEL1,
    ST_FLUSH,
    ST_SEL0,
    ST_HUBNIB,
    ST_NODENIB,
    ST_LDSEL1,
    ST_LDDR,
    ST_LDSEL0,
    ST_DONE,
    ST_FAIL
  } vnd_state_e;
endpackage

// File: rtl/vnd_rst_sync.sv
module vnd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/vnd_cmd_port.sv
// One-outstanding request/response tracker toward the scan engine.
module vnd_cmd_port (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  logic cmd_ready,
  input  logic rsp_done,
  output logic cmd_valid,
  output logic rsp_fire
);
  logic wait_q, wait_d, wait_en;

  assign cmd_valid = issue & ~wait_q;
  assign rsp_fire  = wait_q & rsp_done;

  always_comb begin
    wait_d  = wait_q;
    wait_en = 1'b0;
    if (cmd_valid && cmd_ready) begin
      wait_d  = 1'b1;
      wait_en = 1'b1;
    end else if (rsp_fire) begin
      wait_d  = 1'b0;
      wait_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wait_q <= 1'b0;
    else if (wait_en) wait_q <= wait_d;
  end
endmodule

// File: rtl/vnd_nibble_acc.sv
// Right-shifting word assembler: each nibble enters at the top.
module vnd_nibble_acc #(
  parameter int WORD_W = 32,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic [NIB_W-1:0]  nib_in,
  output logic [WORD_W-1:0] acc_q,
  output logic [WORD_W-1:0] acc_next
);
  assign acc_next = {nib_in, acc_q[WORD_W-1:NIB_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc_q <= '0;
    else if (shift_en) acc_q <= acc_next;
  end
endmodule

// File: rtl/vnd_addr_width.sv
// Number of significant bits in a count (0 for a zero count).
module vnd_addr_width #(
  parameter int CNT_W = 8,
  localparam int AW_W = $clog2(CNT_W + 1)
) (
  input  logic [CNT_W-1:0] count,
  output logic [AW_W-1:0]  width
);
  always_comb begin
    width = '0;
    for (int i = 0; i < CNT_W; i++) begin
      if (count[i]) width = AW_W'(i + 1);
    end
  end
endmodule

// File: rtl/vnode_discover_seq.sv
module vnode_discover_seq
  import vnd_pkg::*;
#(
  parameter int          IR_LEN    = 10,
  parameter logic [15:0] SEL1_CODE = 16'h000E,
  parameter logic [15:0] SEL0_CODE = 16'h000C,
  parameter logic [7:0]  TARGET_ID = 8'h08,
  parameter logic [15:0] VIR_CMD   = 16'h0008,
  parameter int          FLUSH_LEN = 64,
  parameter int          DATA_W    = 64,
  parameter int          LEN_W     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_is_dr,
  output logic [LEN_W-1:0]  cmd_len,
  output logic [DATA_W-1:0] cmd_data,
  input  logic              rsp_done,
  input  logic [NIB_W-1:0]  rsp_data,
  output logic              done,
  output logic              error,
  output logic [ADDR_W-1:0] node_addr,
  output logic [M_W-1:0]    m_width,
  output logic [ID_W-1:0]   node_count,
  output logic [CFG_W-1:0]  hub_cfg
);
  localparam int AW_W  = $clog2(ID_W + 1);
  localparam int NCT_W = $clog2(NIBS_PER_WORD);

  logic rst_sync_n;
  vnd_state_e state_q, state_d;
  logic [NCT_W-1:0]  nib_q, nib_d;
  logic [ID_W-1:0]   idx_q, idx_d;
  logic              found_q, found_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CFG_W-1:0]  cfg_q, cfg_d;
  logic              issue, rsp_fire, upd_en, acc_en, at_rest;
  logic [CFG_W-1:0]  acc_q, acc_nx;
  logic [AW_W-1:0]   aw;
  logic [ID_W-1:0]   nx_id;
  logic              hit, last_node;

  vnd_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_sync_n)
  );

  vnd_cmd_port u_port (
    .clk(clk), .rst_n(rst_sync_n), .issue(issue), .cmd_ready(cmd_ready),
    .rsp_done(rsp_done), .cmd_valid(cmd_valid), .rsp_fire(rsp_fire)
  );

  vnd_nibble_acc #(.WORD_W(CFG_W), .NIB_W(NIB_W)) u_acc (
    .clk(clk), .rst_n(rst_sync_n), .shift_en(acc_en), .nib_in(rsp_data),
    .acc_q(acc_q), .acc_next(acc_nx)
  );

  vnd_addr_width #(.CNT_W(ID_W)) u_aw (
    .count(cfg_q[ID_LSB +: ID_W]), .width(aw)
  );

  assign at_rest = (state_q == ST_IDLE) || (state_q == ST_DONE) || (state_q == ST_FAIL);
  assign issue   = ~at_rest;
  assign acc_en  = rsp_fire && ((state_q == ST_HUBNIB) || (state_q == ST_NODENIB));
  assign upd_en  = rsp_fire || (start && at_rest);
  assign nx_id   = acc_nx[ID_LSB +: ID_W];
  assign hit     = (nx_id == TARGET_ID);
  assign last_node = ({1'b0, idx_q} + ADDR_W'(1)) == {1'b0, cfg_q[ID_LSB +: ID_W]};

  // Next-state logic
  always_comb begin
    state_d = state_q;
    nib_d   = nib_q;
    idx_d   = idx_q;
    found_d = found_q;
    addr_d  = addr_q;
    cfg_d   = cfg_q;
    case (state_q)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (start) begin
          state_d = ST_SEL1;
          nib_d   = '0;
          idx_d   = '0;
          found_d = 1'b0;
          addr_d  = '0;
          cfg_d   = '0;
        end
      end
      ST_SEL1:  if (rsp_fire) state_d = ST_FLUSH;
      ST_FLUSH: if (rsp_fire) state_d = ST_SEL0;
      ST_SEL0:  if (rsp_fire) begin
        state_d = ST_HUBNIB;
        nib_d   = '0;
      end
      ST_HUBNIB: if (rsp_fire) begin
        nib_d = nib_q + 1'b1;
        if (nib_q == NCT_W'(NIBS_PER_WORD - 1)) begin
          cfg_d   = acc_nx;
          idx_d   = '0;
          state_d = (nx_id == '0) ? ST_FAIL : ST_NODENIB;
        end
      end
      ST_NODENIB: if (rsp_fire) begin
        nib_d = nib_q + 1'b1;
        if (nib_q == NCT_W'(NIBS_PER_WORD - 1)) begin
          if (hit) begin
            addr_d  = {1'b0, idx_q} + ADDR_W'(1);
            found_d = 1'b1;
          end
          if (last_node) state_d = (found_q || hit) ? ST_LDSEL1 : ST_FAIL;
          else           idx_d   = idx_q + 1'b1;
        end
      end
      ST_LDSEL1: if (rsp_fire) state_d = ST_LDDR;
      ST_LDDR:   if (rsp_fire) state_d = ST_LDSEL0;
      ST_LDSEL0: if (rsp_fire) state_d = ST_DONE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      nib_q   <= '0;
      idx_q   <= '0;
      found_q <= 1'b0;
      addr_q  <= '0;
      cfg_q   <= '0;
    end else if (upd_en) begin
      state_q <= state_d;
      nib_q   <= nib_d;
      idx_q   <= idx_d;
      found_q <= found_d;
      addr_q  <= addr_d;
      cfg_q   <= cfg_d;
    end
  end

  // Command formatting
  always_comb begin
    cmd_is_dr = 1'b0;
    cmd_len   = LEN_W'(IR_LEN);
    cmd_data  = DATA_W'(SEL1_CODE);
    case (state_q)
      ST_SEL0, ST_LDSEL0: cmd_data = DATA_W'(SEL0_CODE);
      ST_FLUSH: begin
        cmd_is_dr = 1'b1;
        cmd_len   = LEN_W'(FLUSH_LEN);
        cmd_data  = '0;
      end
      ST_HUBNIB, ST_NODENIB: begin
        cmd_is_dr = 1'b1;
        cmd_len   = LEN_W'(NIB_W);
        cmd_data  = '0;
      end
      ST_LDDR: begin
        cmd_is_dr = 1'b1;
        cmd_len   = LEN_W'(aw) + LEN_W'(cfg_q[M_LSB +: M_W]);
        cmd_data  = (DATA_W'(addr_q) << cfg_q[M_LSB +: M_W]) | DATA_W'(VIR_CMD);
      end
      default: ;
    endcase
  end

  assign done       = (state_q == ST_DONE);
  assign error      = (state_q == ST_FAIL);
  assign node_addr  = addr_q;
  assign hub_cfg    = cfg_q;
  assign m_width    = cfg_q[M_LSB +: M_W];
  assign node_count = cfg_q[ID_LSB +: ID_W];
endmodule

// File: rtl/vnd_discover_chk.sv
module vnd_discover_chk
  import vnd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LEN_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_is_dr,
  input logic [LEN_W-1:0]  cmd_len,
  input logic [DATA_W-1:0] cmd_data,
  input logic              rsp_done,
  input logic              done,
  input logic              error,
  input logic [ADDR_W-1:0] node_addr
);
  logic pending_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pending_q <= 1'b0;
    else if (cmd_valid && cmd_ready) pending_q <= 1'b1;
    else if (rsp_done)               pending_q <= 1'b0;
  end

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_is_dr) && $stable(cmd_len) && $stable(cmd_data));

  assert_single_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q |-> !cmd_valid);

  assert_done_error_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  assert_quiet_after_error_R6: assert property (@(posedge clk) disable iff (!rst_n)
    error && !start |=> !cmd_valid);

  assert_done_has_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> node_addr != '0);

  assert_done_after_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(rsp_done));
endmodule

bind vnode_discover_seq vnd_discover_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_is_dr(cmd_is_dr), .cmd_len(cmd_len),
  .cmd_data(cmd_data), .rsp_done(rsp_done), .done(done), .error(error),
  .node_addr(node_addr)
);

// File: tb/vnode_discover_seq_tb.sv
module vnode_discover_seq_tb;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic        cmd_valid;
  logic        cmd_ready;
  logic        cmd_is_dr;
  logic [8:0]  cmd_len;
  logic [63:0] cmd_data;
  logic        rsp_done;
  logic [3:0]  rsp_data;
  logic        done;
  logic        error;
  logic [8:0]  node_addr;
  logic [7:0]  m_width;
  logic [7:0]  node_count;
  logic [31:0] hub_cfg;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  bit          exp_dr[$];
  int          exp_len[$];
  logic [63:0] exp_data[$];
  string       exp_tag[$];
  logic [31:0] words[$];
  logic [7:0]  node_ids[$];
  int          nib_k = 0;

  vnode_discover_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_is_dr(cmd_is_dr), .cmd_len(cmd_len),
    .cmd_data(cmd_data), .rsp_done(rsp_done), .rsp_data(rsp_data),
    .done(done), .error(error), .node_addr(node_addr), .m_width(m_width),
    .node_count(node_count), .hub_cfg(hub_cfg)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
    end
  endtask

  task automatic push_exp(input bit dr, input int len, input logic [63:0] d, input string tag);
    exp_dr.push_back(dr);
    exp_len.push_back(len);
    exp_data.push_back(d);
    exp_tag.push_back(tag);
  endtask

  // Scan engine and hub model
  initial begin
    cmd_ready = 0;
    rsp_done  = 0;
    rsp_data  = 0;
    forever begin
      @(negedge clk);
      if (rst_n && cmd_valid) begin
        bit          s_dr;
        int          s_len;
        logic [63:0] s_data;
        logic [3:0]  resp;
        int          d;
        s_dr = cmd_is_dr; s_len = int'(cmd_len); s_data = cmd_data;
        d = int'($urandom % 3);
        repeat (d) begin
          @(negedge clk);
          chk(cmd_valid && cmd_is_dr == s_dr && int'(cmd_len) == s_len && cmd_data == s_data,
              "R9", "request held while not ready", cmd_data, s_data);
        end
        cmd_ready = 1;
        if (exp_dr.size() == 0) begin
          chk(0, "R6", "unexpected command", s_data, 0);
        end else begin
          bit e_dr; int e_len; logic [63:0] e_data; string e_tag;
          e_dr = exp_dr.pop_front(); e_len = exp_len.pop_front();
          e_data = exp_data.pop_front(); e_tag = exp_tag.pop_front();
          chk(s_dr == e_dr, e_tag, "scan kind", 64'(s_dr), 64'(e_dr));
          chk(s_len == e_len, e_tag, "scan length", 64'(s_len), 64'(e_len));
          chk(s_data == e_data, e_tag, "scan payload", s_data, e_data);
        end
        resp = 0;
        if (!s_dr && s_data == 64'h0C) nib_k = 0;
        if (s_dr && s_len == 4) begin
          logic [31:0] w;
          w = (nib_k / 8 < words.size()) ? words[nib_k / 8] : 32'h0;
          resp = 4'(w >> (4 * (nib_k % 8)));
          nib_k++;
        end
        @(negedge clk);
        cmd_ready = 0;
        d = int'($urandom % 3);
        repeat (d) begin
          @(negedge clk);
          chk(!cmd_valid, "R9", "no request while pending", 64'(cmd_valid), 0);
        end
        chk(!cmd_valid, "R9", "no request before response", 64'(cmd_valid), 0);
        rsp_done = 1;
        rsp_data = resp;
        @(negedge clk);
        rsp_done = 0;
        rsp_data = 0;
      end
    end
  end

  // Compared on every clock: done and error never together
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      compared++;
      if (done && error) begin
        mismatched++;
        $display("FAIL R6 done and error both high: actual 1 expected 0");
      end
    end
  end

  task automatic run_case(input logic [31:0] cfg, input bit busy_start, input string name);
    int n, m, last, aw, c, t;
    bit ok;
    n = int'(cfg[26:19]);
    m = int'(cfg[7:0]);
    words.delete();
    words.push_back(cfg);
    last = 0;
    for (int i = 0; i < n; i++) begin
      words.push_back((32'h1 << 27) | (32'(node_ids[i]) << 19) | (32'h06E << 8) | 32'(i));
      if (node_ids[i] == 8'h08) last = i + 1;
    end
    aw = 0; c = n;
    while (c != 0) begin c = c >> 1; aw++; end
    push_exp(0, 10, 64'h0E, "R2");
    push_exp(1, 64, 64'h0, "R2");
    push_exp(0, 10, 64'h0C, "R2");
    for (int i = 0; i < 8; i++) push_exp(1, 4, 64'h0, "R3");
    for (int i = 0; i < 8 * n; i++) push_exp(1, 4, 64'h0, "R5");
    ok = (last != 0);
    if (ok) begin
      push_exp(0, 10, 64'h0E, "R7");
      push_exp(1, aw + m, (64'(last) << m) | 64'h8, "R8");
      push_exp(0, 10, 64'h0C, "R7");
    end
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    if (busy_start) begin
      repeat (25) @(negedge clk);
      start = 1;                       // R10: ignored mid-run
      @(negedge clk); start = 0;
    end
    t = 0;
    while (!(done || error) && t < 20000) begin @(negedge clk); t++; end
    repeat (20) @(negedge clk);
    $display("case %s", name);
    chk(done == ok, "R7", "done", 64'(done), 64'(ok));
    chk(error == !ok, "R6", "error", 64'(error), 64'(!ok));
    chk(exp_dr.size() == 0, "R10", "script fully issued", 64'(exp_dr.size()), 0);
    chk(hub_cfg == cfg, "R3", "hub_cfg", 64'(hub_cfg), 64'(cfg));
    chk(int'(node_count) == n, "R4", "node_count", 64'(node_count), 64'(n));
    chk(int'(m_width) == m, "R4", "m_width", 64'(m_width), 64'(m));
    chk(int'(node_addr) == last, "R5", "node_addr", 64'(node_addr), 64'(last));
    exp_dr.delete(); exp_len.delete(); exp_data.delete(); exp_tag.delete();
  endtask

  function automatic logic [31:0] mk_cfg(input int n, input int m);
    return (32'h1 << 27) | (32'(n) << 19) | (32'h06E << 8) | 32'(m);
  endfunction

  initial begin
    rst_n = 0;
    start = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!cmd_valid, "R1", "cmd_valid", 64'(cmd_valid), 0);
    chk(!done && !error, "R1", "done/error", 64'({done, error}), 0);
    chk(node_addr == 0 && hub_cfg == 0, "R1", "node_addr/hub_cfg", 64'(hub_cfg), 0);
    chk(m_width == 0 && node_count == 0, "R1", "m_width/node_count", 64'({m_width, node_count}), 0);

    node_ids = '{8'h84, 8'h08, 8'h00};
    run_case(mk_cfg(3, 4), 1, "single match, start while busy");
    node_ids = '{8'h08, 8'h00, 8'h08, 8'h04, 8'h08};
    run_case(mk_cfg(5, 8), 0, "several matches, last kept");
    node_ids = '{8'h00, 8'h04};
    run_case(mk_cfg(2, 4), 0, "no match");
    node_ids = '{8'h08};
    run_case(mk_cfg(1, 1), 0, "one node, m of 1, restart after error");
    node_ids.delete();
    run_case(mk_cfg(0, 4), 0, "zero nodes");
    node_ids = '{8'h00, 8'h00, 8'h84, 8'h00, 8'h04, 8'h00, 8'h00, 8'h08};
    run_case(mk_cfg(8, 3), 0, "eight nodes, match at end");
    node_ids = '{8'h84, 8'h08, 8'h00};
    run_case(mk_cfg(3, 4), 0, "repeat after done");

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    finished = 1;
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule